// File: doc/BRIEF.md
# Ownership-Switched Banked Working Memory

This block is a byte-addressable working memory built from eight 32-bit banks. Two requesters compete for it: a wide vector port that can address every bank separately in one cycle (256 bits in total), and a narrow system port used by a CPU (up to 32 bits) or a DMA-style master (up to 128 bits). Only one side is connected at a time. A single ownership bit in a control register drives a static mux that picks the side, and the other side is blocked.

Blocked accesses get an error response with zero read data, and they never reach the banks. The first blocked access that is not a debug access is logged: an error code and its byte address are stored, and a raw interrupt flag is set. This log is held until software clears the flag. Debug accesses are refused in the same way but leave no record. System accesses must also respect size and alignment rules. An access that breaks them is refused without being logged.

Top module: `wbuf_owned_mem`

## Requirements
- R1: A byte address splits into three fields. Bits [1:0] are the byte within a 32-bit word, bits [4:2] are the bank, and the upper bits are the word index. A system write changes only the bytes it covers, and a later read from either port returns them.
- R2: Each vector bank b has its own request, write strobe, word index, four byte enables and 32-bit data lane at bits [32b+31:32b]. While the vector side owns the memory, a read on a requested bank returns data on that lane one cycle after the request.
- R3: Control register offset 0, bit 16, holds the owner. Value 0 gives the memory to the system port and value 1 gives it to the vector port. The bit resets to 0.
- R4: The system size field is the log2 of the byte count. A system access is refused when size > 4, when a CPU access has size > 2, or when the address is not a multiple of the byte count. A refused access returns sys_err one cycle later, returns zero data, does not write and is not logged. Byte addr[3:0]+k of an access travels on lane bits [8(addr[3:0]+k)+7 : 8(addr[3:0]+k)] of the 128-bit data.
- R5: An access by the side that does not own the memory returns an error one cycle later with all-zero read data, and it does not write the memory.
- R6: A logged violation writes an error code to offset 1, bits [1:0]. The codes are 1 for a vector access, 2 for a system read and 3 for a system write. It also writes a byte address to offset 2: for a system access this is sys_addr, and for a vector access it is the word address of the lowest-numbered requesting bank. The raw flag at offset 3, bit 0, is set.
- R7: While the raw flag is set, later violations leave offsets 1 and 2 unchanged. Writing a 1 to offset 3, bit 0, clears the flag. A violation in the same cycle as the clear is captured and sets the flag again.
- R8: A system access with sys_dbg high made while the system side does not own the memory gets an error response but changes neither the log nor the raw flag.
- R9: The irq output is high exactly when the raw flag and the enable bit at offset 4, bit 0, are both 1.
- R10: An accepted system read returns zero on every byte lane outside the bytes it accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked violation interrupt |
| vec_req | input | 8 | Per-bank vector request |
| vec_we | input | 8 | Per-bank vector write strobe |
| vec_idx | input | 48 | Per-bank word index, 6 bits per bank |
| vec_be | input | 32 | Per-bank byte enables, 4 bits per bank |
| vec_wdata | input | 256 | Vector write data, 32 bits per bank |
| vec_rdata | output | 256 | Vector read data, one cycle after request |
| vec_err | output | 1 | Vector request was blocked (one cycle later) |
| sys_req | input | 1 | System request |
| sys_we | input | 1 | System write strobe |
| sys_cpu | input | 1 | Request comes from the CPU (32-bit limit) |
| sys_dbg | input | 1 | Debug access, never logged |
| sys_addr | input | 11 | System byte address |
| sys_size | input | 3 | log2 of the access byte count |
| sys_wdata | input | 128 | System write data in window lanes |
| sys_rdata | output | 128 | System read data in window lanes |
| sys_ack | output | 1 | Response valid, one cycle after sys_req |
| sys_err | output | 1 | Error response |

## Verification
A wrong ownership bit shows up in the cycle after the next request from either side: the error flag and the zeroed data appear at the wrong port. A corrupted bank word or byte-enable path stays hidden until that location is read again. The bench therefore keeps a byte-level model and checks every read against it, including reads issued after the owner changes. A capture register that is not held shows as a changed error code or address on the very next register read after a second violation.

// File: rtl/wbuf_pkg.sv
// Package: shared constants and types for the ownership-switched working memory.
// Assumes a fixed geometry of eight 32-bit banks and a 128-bit system window.
package wbuf_pkg;
    localparam int NBANK      = 8;
    localparam int LANE_W     = 32;
    localparam int LANE_BYTES = LANE_W / 8;
    localparam int WIN_BYTES  = 16;
    localparam int ROW_BYTES  = NBANK * LANE_BYTES;
    localparam int OWN_BIT    = 16;

    typedef enum logic [1:0] {
        VIOL_NONE   = 2'd0,
        VIOL_VECTOR = 2'd1,
        VIOL_SYS_RD = 2'd2,
        VIOL_SYS_WR = 2'd3
    } viol_code_e;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_CODE    = 3'd1;
    localparam logic [2:0] REG_ADDR    = 3'd2;
    localparam logic [2:0] REG_IRQRAW  = 3'd3;
    localparam logic [2:0] REG_IRQEN   = 3'd4;
endpackage

// File: rtl/wbuf_bank.sv
// Module: one 32-bit bank with per-byte write enables and a registered read port.
// Assumes a single access per cycle. A read that coincides with a write returns the old word.
module wbuf_bank #(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            we,
    input  logic [IDXW-1:0] idx,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata
);
    logic [31:0] mem [DEPTH];

    // Byte-wise write, one process per byte lane
    for (genvar j = 0; j < 4; j++) begin : g_byte
        always_ff @(posedge clk) begin
            if (en && we && be[j]) begin
                mem[idx][8*j +: 8] <= wdata[8*j +: 8];
            end
        end
    end

    // Registered read of the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/wbuf_sys_decode.sv
// Module: decodes a system request into a legality flag, a window mask and row byte enables.
// Assumes naturally aligned power-of-two sizes. An aligned access of 16 bytes or less
// therefore never crosses a 128-bit boundary.
module wbuf_sys_decode
    import wbuf_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [AW-1:0]          addr,
    input  logic [2:0]             size,
    input  logic                   cpu,
    output logic                   fmt_ok,
    output logic                   half,
    output logic [AW-6:0]          idx,
    output logic [WIN_BYTES-1:0]   win_mask,
    output logic [ROW_BYTES-1:0]   row_be
);
    logic [5:0] lo;
    logic [5:0] nbytes;

    // Size legality, alignment and the byte range inside the 16-byte window
    always_comb begin
        lo     = {2'b00, addr[3:0]};
        nbytes = (size <= 3'd4) ? (6'd1 << size) : 6'd0;
        fmt_ok = (size <= 3'd4) && !(cpu && (size > 3'd2))
                 && ((addr[3:0] & (nbytes[3:0] - 4'd1)) == 4'd0);
        half   = addr[4];
        idx    = addr[AW-1:5];
        for (int k = 0; k < WIN_BYTES; k++) begin
            win_mask[k] = (6'(k) >= lo) && (6'(k) < lo + nbytes);
        end
    end

    // Spread the window mask onto the half of the row that the address selects
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            for (int j = 0; j < LANE_BYTES; j++) begin
                row_be[b*LANE_BYTES + j] = ((b >= NBANK/2) == half)
                    && win_mask[(b % (NBANK/2))*LANE_BYTES + j];
            end
        end
    end
endmodule

// File: rtl/wbuf_err_regs.sv
// Module: control register (owner bit), violation capture, raw IRQ flag (W1C) and IRQ enable.
// Assumes at most one violation source per cycle. Only the non-owner side can violate.
module wbuf_err_regs
    import wbuf_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          owner,
    input  logic          viol,
    input  viol_code_e    viol_code,
    input  logic [AW-1:0] viol_addr,
    output logic          irq
);
    logic          owner_q;
    logic          irq_en_q;
    logic          raw_q;
    viol_code_e    code_q;
    logic [AW-1:0] addr_q;
    logic          clr;

    assign clr   = cfg_we && (cfg_addr == REG_IRQRAW) && cfg_wdata[0];
    assign owner = owner_q;
    assign irq   = raw_q & irq_en_q;

    // Software-writable fields and the first-violation capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= 1'b0;
            irq_en_q <= 1'b0;
            raw_q    <= 1'b0;
            code_q   <= VIOL_NONE;
            addr_q   <= '0;
        end else begin
            if (cfg_we && cfg_addr == REG_CTRL)  owner_q  <= cfg_wdata[OWN_BIT];
            if (cfg_we && cfg_addr == REG_IRQEN) irq_en_q <= cfg_wdata[0];
            if (viol && (!raw_q || clr)) begin
                code_q <= viol_code;
                addr_q <= viol_addr;
            end
            raw_q <= (raw_q && !clr) || viol;
        end
    end

    // Register read mux
    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            REG_CTRL:   cfg_rdata[OWN_BIT] = owner_q;
            REG_CODE:   cfg_rdata[1:0]     = code_q;
            REG_ADDR:   cfg_rdata[AW-1:0]  = addr_q;
            REG_IRQRAW: cfg_rdata[0]       = raw_q;
            REG_IRQEN:  cfg_rdata[0]       = irq_en_q;
            default:    cfg_rdata          = '0;
        endcase
    end

    // R7: an uncleared flag freezes the captured code and address
    p_hold_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q && !clr |=> $stable(code_q) && $stable(addr_q));

    // R6: the raw flag only rises after a logged violation
    p_raw_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(viol));
endmodule

// File: rtl/wbuf_owned_mem.sv
// Module: top of the working memory. It holds eight banks, the static mux chosen by the
// owner bit, blocking and response logic for both ports, and violation logging.
// Assumes vector and system requests are single-cycle pulses with responses one cycle later.
module wbuf_owned_mem
    import wbuf_pkg::*;
#(
    parameter int BANK_DEPTH = 64,
    localparam int IDXW = $clog2(BANK_DEPTH),
    localparam int AW   = IDXW + 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic                    irq,
    input  logic [NBANK-1:0]        vec_req,
    input  logic [NBANK-1:0]        vec_we,
    input  logic [NBANK*IDXW-1:0]   vec_idx,
    input  logic [ROW_BYTES-1:0]    vec_be,
    input  logic [NBANK*LANE_W-1:0] vec_wdata,
    output logic [NBANK*LANE_W-1:0] vec_rdata,
    output logic                    vec_err,
    input  logic                    sys_req,
    input  logic                    sys_we,
    input  logic                    sys_cpu,
    input  logic                    sys_dbg,
    input  logic [AW-1:0]           sys_addr,
    input  logic [2:0]              sys_size,
    input  logic [WIN_BYTES*8-1:0]  sys_wdata,
    output logic [WIN_BYTES*8-1:0]  sys_rdata,
    output logic                    sys_ack,
    output logic                    sys_err
);
    logic                   owner;
    logic                   fmt_ok;
    logic                   half;
    logic [IDXW-1:0]        sys_idx;
    logic [WIN_BYTES-1:0]   win_mask;
    logic [ROW_BYTES-1:0]   row_be;
    logic                   sys_go;
    logic                   viol;
    viol_code_e             viol_code;
    logic [AW-1:0]          vec_vaddr;
    logic [AW-1:0]          viol_addr;
    logic [31:0]            bank_rd [NBANK];

    logic                   vec_ok_q;
    logic                   vec_err_q;
    logic                   sys_ack_q;
    logic                   sys_err_q;
    logic                   half_q;
    logic [WIN_BYTES-1:0]   mask_q;

    wbuf_sys_decode #(.AW(AW)) u_dec (
        .addr(sys_addr), .size(sys_size), .cpu(sys_cpu),
        .fmt_ok(fmt_ok), .half(half), .idx(sys_idx),
        .win_mask(win_mask), .row_be(row_be)
    );

    assign sys_go = sys_req && !owner && fmt_ok;

    // Static mux and bank array: the owner bit picks which side drives each bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic            en;
        logic            we;
        logic [IDXW-1:0] idx;
        logic [3:0]      be;
        logic [31:0]     wd;
        always_comb begin
            if (owner) begin
                en  = vec_req[b];
                we  = vec_we[b];
                idx = vec_idx[b*IDXW +: IDXW];
                be  = vec_be[b*LANE_BYTES +: LANE_BYTES];
                wd  = vec_wdata[b*LANE_W +: LANE_W];
            end else begin
                en  = sys_go && ((b >= NBANK/2) == half)
                      && (!sys_we || (|row_be[b*LANE_BYTES +: LANE_BYTES]));
                we  = sys_we;
                idx = sys_idx;
                be  = row_be[b*LANE_BYTES +: LANE_BYTES];
                wd  = sys_wdata[(b % (NBANK/2))*LANE_W +: LANE_W];
            end
        end
        wbuf_bank #(.DEPTH(BANK_DEPTH)) u_bank (
            .clk(clk), .rst_n(rst_n), .en(en), .we(we), .idx(idx),
            .be(be), .wdata(wd), .rdata(bank_rd[b])
        );
        assign vec_rdata[b*LANE_W +: LANE_W] = vec_ok_q ? bank_rd[b] : '0;
    end

    // Byte address of the lowest-numbered requesting vector bank
    always_comb begin
        vec_vaddr = '0;
        for (int b = NBANK-1; b >= 0; b--) begin
            if (vec_req[b]) vec_vaddr = {vec_idx[b*IDXW +: IDXW], 3'(b), 2'b00};
        end
    end

    // Violation source: only the non-owner side can violate, and debug accesses are exempt
    always_comb begin
        viol      = 1'b0;
        viol_code = VIOL_NONE;
        viol_addr = vec_vaddr;
        if (owner && sys_req && !sys_dbg) begin
            viol      = 1'b1;
            viol_code = sys_we ? VIOL_SYS_WR : VIOL_SYS_RD;
            viol_addr = sys_addr;
        end else if (!owner && (|vec_req)) begin
            viol      = 1'b1;
            viol_code = VIOL_VECTOR;
        end
    end

    wbuf_err_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .owner(owner),
        .viol(viol), .viol_code(viol_code), .viol_addr(viol_addr), .irq(irq)
    );

    // Response state for both ports, aligned with the registered bank reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_ok_q  <= 1'b0;
            vec_err_q <= 1'b0;
            sys_ack_q <= 1'b0;
            sys_err_q <= 1'b0;
            half_q    <= 1'b0;
            mask_q    <= '0;
        end else begin
            vec_ok_q  <= owner;
            vec_err_q <= !owner && (|vec_req);
            sys_ack_q <= sys_req;
            sys_err_q <= sys_req && (owner || !fmt_ok);
            half_q    <= half;
            mask_q    <= (sys_go && !sys_we) ? win_mask : '0;
        end
    end

    // System read return: pick the window half, then zero the lanes outside the access
    always_comb begin
        for (int w = 0; w < NBANK/2; w++) begin
            for (int j = 0; j < LANE_BYTES; j++) begin
                sys_rdata[(w*LANE_BYTES + j)*8 +: 8] =
                    mask_q[w*LANE_BYTES + j]
                    ? (half_q ? bank_rd[w + NBANK/2][8*j +: 8] : bank_rd[w][8*j +: 8])
                    : 8'h00;
            end
        end
    end

    assign vec_err = vec_err_q;
    assign sys_ack = sys_ack_q;
    assign sys_err = sys_err_q;

    // R5: a system request while the vector side owns gets an error and zero data
    p_sys_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req && owner |=> sys_err && (sys_rdata == '0));

    // R5: a vector request while the system side owns gets an error and zero data
    p_vec_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|vec_req) && !owner |=> vec_err && (vec_rdata == '0));

    // R4: an illegal size or alignment from the owning system side is refused
    p_fmt_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req && !owner && !fmt_ok |=> sys_err && (sys_rdata == '0));

    // R4: the row byte enables never leave the selected 16-byte half
    p_be_in_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req |-> (half ? (row_be[ROW_BYTES/2-1:0] == '0)
                          : (row_be[ROW_BYTES-1:ROW_BYTES/2] == '0)));
endmodule

// File: tb/wbuf_owned_mem_tb.sv
module wbuf_owned_mem_tb;
    localparam int DEPTH = 64;
    localparam int IDXW  = 6;
    localparam int AW    = 11;
    localparam int NB    = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          irq;
    logic [7:0]    vec_req = '0, vec_we = '0;
    logic [47:0]   vec_idx = '0;
    logic [31:0]   vec_be = '0;
    logic [255:0]  vec_wdata = '0, vec_rdata;
    logic          vec_err;
    logic          sys_req = 1'b0, sys_we = 1'b0, sys_cpu = 1'b0, sys_dbg = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [2:0]    sys_size = '0;
    logic [127:0]  sys_wdata = '0, sys_rdata;
    logic          sys_ack, sys_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model [NB];

    always #4 clk = ~clk;

    wbuf_owned_mem #(.BANK_DEPTH(DEPTH)) u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit fmt_ok(bit cpu, int addr, int size);
        return size <= 4 && !(cpu && size > 2) && (addr % (1 << size)) == 0;
    endfunction

    function automatic logic [127:0] exp_read(int addr, int size);
        logic [127:0] r = '0;
        int lo = addr % 16;
        for (int k = 0; k < (1 << size); k++) r[(lo+k)*8 +: 8] = model[addr+k];
        return r;
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic sys_op(input bit we, input bit cpu, input bit dbg, input int addr, input int size,
                          input logic [127:0] wd, output logic [127:0] rd, output bit er);
        sys_req = 1'b1; sys_we = we; sys_cpu = cpu; sys_dbg = dbg;
        sys_addr = AW'(addr); sys_size = 3'(size); sys_wdata = wd;
        @(negedge clk);
        rd = sys_rdata; er = sys_err;
        sys_req = 1'b0; sys_dbg = 1'b0;
    endtask

    task automatic model_sys_write(int addr, int size, logic [127:0] wd);
        for (int k = 0; k < (1 << size); k++) model[addr+k] = wd[((addr%16)+k)*8 +: 8];
    endtask

    // Drives one vector cycle and checks read lanes when the vector side owns the memory
    task automatic vec_op(input logic [7:0] rq, input logic [7:0] we, input logic [47:0] ix,
                          input logic [31:0] be, input logic [255:0] wd, input bit owned);
        logic [255:0] exp = '0;
        for (int b = 0; b < 8; b++)
            for (int j = 0; j < 4; j++)
                exp[b*32+j*8 +: 8] = model[int'(ix[b*6 +: 6])*32 + b*4 + j];
        vec_req = rq; vec_we = we; vec_idx = ix; vec_be = be; vec_wdata = wd;
        @(negedge clk);
        if (owned) begin
            for (int b = 0; b < 8; b++) begin
                if (rq[b] && !we[b])
                    check(vec_rdata[b*32 +: 32] == exp[b*32 +: 32], "R2 vector read lane",
                          vec_rdata[b*32 +: 32], exp[b*32 +: 32]);
                if (rq[b] && we[b])
                    for (int j = 0; j < 4; j++)
                        if (be[b*4+j]) model[int'(ix[b*6 +: 6])*32 + b*4 + j] = wd[b*32+j*8 +: 8];
            end
            if (rq != 0) check(vec_err == 1'b0, "R2 vector err low when owned", vec_err, 0);
        end
        vec_req = '0; vec_we = '0;
    endtask

    initial begin : main
        logic [31:0]  d;
        logic [127:0] rd, wd;
        bit           er;
        int           addr, size;
        bit           we, cpu;
        logic [7:0]   rq, wv;
        logic [47:0]  ix;
        logic [255:0] vw;
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < NB; i++) model[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Zero the whole memory through the system port so the model is known
        for (int a = 0; a < NB; a += 16) sys_op(1, 0, 0, a, 4, '0, rd, er);

        cfg_read(3'd0, d); check(d == 0, "R3 owner resets to system", d, 0);
        cfg_read(3'd3, d); check(d == 0, "R6 raw flag reset", d, 0);
        check(irq == 0, "R9 irq reset", irq, 0);

        // Directed: 16-byte write to the upper half of row 3, read back in pieces
        wd = {$urandom, $urandom, $urandom, $urandom};
        sys_op(1, 0, 0, 3*32+16, 4, wd, rd, er); model_sys_write(3*32+16, 4, wd);
        check(er == 0, "R1 full window write accepted", er, 0);
        sys_op(0, 1, 0, 3*32+20, 2, '0, rd, er);
        check(rd == exp_read(3*32+20, 2), "R10 cpu word read lanes", rd, exp_read(3*32+20, 2));
        // Directed: misaligned word refused and not written
        sys_op(1, 1, 0, 3*32+18, 2, '1, rd, er);
        check(er == 1, "R4 misaligned refused", er, 1);
        sys_op(0, 0, 0, 3*32+16, 4, '0, rd, er);
        check(rd == exp_read(3*32+16, 4), "R4 refused write left memory", rd, exp_read(3*32+16, 4));
        // Directed: CPU 8-byte access refused, size 5 refused
        sys_op(0, 1, 0, 64, 3, '0, rd, er);
        check(er == 1 && rd == 0, "R4 cpu wider than 32 bits", {er, rd}, {1'b1, 128'h0});
        sys_op(0, 0, 0, 0, 5, '0, rd, er);
        check(er == 1, "R4 size above 16 bytes", er, 1);
        cfg_read(3'd3, d); check(d == 0, "R4 refusals not logged", d, 0);

        // Random system traffic while the system side owns the memory
        for (int i = 0; i < 400; i++) begin
            size = $urandom_range(0, 5);
            addr = $urandom_range(0, NB - 17);
            if ($urandom_range(0, 3) != 0 && size <= 4) addr = addr & ~((1 << size) - 1);
            we = $urandom_range(0, 1); cpu = $urandom_range(0, 1);
            wd = {$urandom, $urandom, $urandom, $urandom};
            sys_op(we, cpu, 0, addr, size, wd, rd, er);
            check(er == !fmt_ok(cpu, addr, size), "R4 legality response", er, !fmt_ok(cpu, addr, size));
            check(sys_ack == 1, "R4 ack one cycle later", sys_ack, 1);
            if (fmt_ok(cpu, addr, size)) begin
                if (we) model_sys_write(addr, size, wd);
                else check(rd == exp_read(addr, size), "R1 R10 random read", rd, exp_read(addr, size));
            end else begin
                check(rd == 0, "R4 refused read zero", rd, 0);
            end
        end
        cfg_read(3'd3, d); check(d == 0, "R4 random refusals not logged", d, 0);

        // Vector access while not owner: blocked and logged
        ix = {6'd9, 6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3, 6'd2};
        vec_op(8'b1011_0100, 8'hFF, ix, '1, '1, 0);
        check(vec_err == 1 && vec_rdata == 0, "R5 vector blocked", {vec_err, vec_rdata}, {1'b1, 256'h0});
        vec_req = 8'h01;
        cfg_read(3'd1, d); check(d == 1, "R6 vector code", d, 1);
        vec_req = 8'h00;
        cfg_read(3'd2, d); check(d == 4*32 + 2*4, "R6 vector lowest-bank address", d, 4*32 + 2*4);
        cfg_read(3'd3, d); check(d == 1, "R6 raw flag set", d, 1);
        check(irq == 0, "R9 irq masked", irq, 0);
        cfg_write(3'd4, 32'h1);
        check(irq == 1, "R9 irq enabled", irq, 1);
        // Second violation must not overwrite
        vec_op(8'h80, 8'h00, {6'd33, 42'h0}, '0, '0, 0);
        cfg_read(3'd2, d); check(d == 4*32 + 2*4, "R7 address held", d, 4*32 + 2*4);
        cfg_write(3'd3, 32'h1);
        cfg_read(3'd3, d); check(d == 0, "R7 W1C clears", d, 0);
        check(irq == 0, "R9 irq follows clear", irq, 0);
        // Clear and a new violation in the same cycle: captured again
        cfg_write(3'd3, 32'h1);
        cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 32'h1;
        vec_op(8'h80, 8'h00, {6'd33, 42'h0}, '0, '0, 0);
        cfg_we = 1'b0;
        cfg_read(3'd3, d); check(d == 1, "R7 capture during clear sets flag", d, 1);
        cfg_read(3'd2, d); check(d == 33*32 + 7*4, "R7 capture during clear address", d, 33*32 + 7*4);
        cfg_write(3'd3, 32'h1);

        // Hand the memory to the vector side
        cfg_write(3'd0, 32'h0001_0000);
        cfg_read(3'd0, d); check(d == 32'h0001_0000, "R3 owner set to vector", d, 32'h0001_0000);
        // The blocked vector write above must not have landed
        vec_op(8'b1011_0100, 8'h00, ix, '0, '0, 1);
        for (int i = 0; i < 300; i++) begin
            rq = 8'($urandom); wv = 8'($urandom);
            ix = {$urandom, $urandom};
            vw = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            vec_op(rq, wv, ix, $urandom, vw, 1);
        end

        // System access while vector owns
        sys_op(0, 0, 1, 48, 4, '0, rd, er);
        check(er == 1 && rd == 0, "R8 debug blocked", {er, rd}, {1'b1, 128'h0});
        cfg_read(3'd3, d); check(d == 0, "R8 debug not logged", d, 0);
        sys_op(1, 1, 0, 200, 2, '1, rd, er);
        check(er == 1, "R5 system write blocked", er, 1);
        cfg_read(3'd1, d); check(d == 3, "R6 system write code", d, 3);
        cfg_read(3'd2, d); check(d == 200, "R6 system address", d, 200);
        cfg_write(3'd3, 32'h1);
        sys_op(0, 0, 0, 64, 3, '0, rd, er);
        cfg_read(3'd1, d); check(d == 2, "R6 system read code", d, 2);
        cfg_write(3'd3, 32'h1);

        // Back to system owner: memory written by vector must be visible, blocked write absent
        cfg_write(3'd0, 32'h0);
        for (int a = 0; a < NB; a += 16) begin
            sys_op(0, 0, 0, a, 4, '0, rd, er);
            check(rd == exp_read(a, 4) && er == 0, "R1 R2 cross-port readback", rd, exp_read(a, 4));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end
endmodule